// File: doc/BRIEF.md
# Content-Adaptive Backlight Dimming Controller

The block runs once per displayed frame. It decides how far the panel backlight can be lowered and how much the pixel values must be raised to make up for it. With each frame it receives a start strobe and samples a set of inputs:

- eight luminance-histogram bin counts;
- a normaliser, which is the active pixel count divided by 100;
- the user backlight level;
- a low-limit threshold.

From these it produces three outputs, all registered and announced by a one-cycle done pulse:

- an 8-bit adjustment index;
- a 9-bit dimming value, used as a PWM scale out of 256;
- a 7-bit page select into an external compensation lookup table.

The computation has five stages:

1. Each bin count is divided by the normaliser in a shared sequential divider, and the quotients are accumulated into cumulative shares.
2. The shares are scanned from the brightest bin downward for the first bin whose share is below 95. That bin picks a raw index from a fixed eight-entry table.
3. The raw index is pushed into a short history, and the history is smoothed by a weighted sum with weights totalling 1024.
4. When the user backlight lies just above the low limit, the smoothed index is pulled linearly toward full brightness.
5. The result is clamped to the table's lowest entry.

The algorithm is gated in three ways. It is skipped on alternate frames. It is replaced by a full-brightness result on the first processed frame after enabling. It is also replaced by a full-brightness result whenever the user backlight is below the low limit.

Top module: `bldim_top`

## Requirements
- R1: While `enable` is low, a `start` pulse produces no `done` and leaves all three outputs unchanged.
- R2: With `enable` high, accepted starts alternate between processed and skipped, beginning with processed on the first start after `enable` rises. A skipped start produces no `done` and leaves the outputs unchanged. Lowering `enable` restarts the alternation.
- R3: While `enable` is low, every history entry is held at 255. The first processed frame after `enable` rises outputs index 255, dimming 256 and page 127 without running the algorithm, and it does not alter the history.
- R4: The effective low limit is `lowLimit` when `lowLimit` is 20 or more, and 85 otherwise.
- R5: On a processed frame that is not the first, a `backlight` below the effective low limit gives index 255, dimming 256 and page 127, and refills every history entry with 255.
- R6: Let size be `normSize`, or 1 when `normSize` is 0. The share of bin i is the sum over bins 0..i of count/size, each quotient truncated. Bin k occupies bits [24k+23:24k] of `binCounts`. Let j be the highest bin whose share is below 95. The raw index is table[7] when j is 7, table[j+1] when j is 1 to 6, and table[0] when j is 0 or no bin qualifies. The default table is 128, 144, 160, 176, 192, 208, 224, 240 for entries 0 to 7.
- R7: The raw index enters history slot 7 (newest), and every older entry moves down one slot, with slot 0 dropped. The smoothed index is the sum of weight[s]*history[s], shifted right by 10. The default weights for slots 0..7 are 64, 64, 96, 128, 128, 160, 192, 192.
- R8: Let L be the effective low limit and H = L + (255-L)/5. When `backlight` is below H, the index becomes index + (255-index)*(H-backlight)/(H-L), using integer division.
- R9: The output index is at least table[0]. `dimming` equals index+1, and `lutPage` equals index-128.
- R10: After reset the outputs are index 255, dimming 256, page 127 and `done` low. `done` is a single-cycle pulse, and the outputs change only in the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low clears the history, the alternation and the first-run state |
| start | input | 1 | One-cycle frame strobe; the inputs below are sampled with it |
| binCounts | input | 192 | Eight histogram counts, 24 bits each, bin 0 in the low bits |
| normSize | input | 24 | Pixel count divided by 100 |
| backlight | input | 8 | User backlight level |
| lowLimit | input | 8 | Requested low-limit threshold |
| adjIndex | output | 8 | Final adjustment index |
| dimming | output | 9 | Backlight scale, index+1 |
| lutPage | output | 7 | Compensation table page, index-128 |
| done | output | 1 | One-cycle pulse marking new outputs |

## Verification
The hardest state to reach is a processed frame whose result depends on a history that has been partly refilled. Reaching it needs an enable edge, a first-run bypass, a skipped odd start and then a mix of below-limit and algorithm frames, all in the right order. The stimulus runs a long random sequence of frames with occasional enable drops, random backlight and limit values (some limits below 20), and histograms scaled so that the 95 crossing falls in varying bins. Directed frames force the edge cases: no qualifying bin, bin 0 alone, bin 7, a zero normaliser, and backlight exactly at the limit where the ramp reaches 255.

// File: rtl/bldim_pkg.sv
package bldim_pkg;
  localparam int NUM_BINS = 8;
  localparam int BIN_W = $clog2(NUM_BINS);
  localparam logic [7:0] FALLBACK_LOW = 8'd85;
  localparam logic [7:0] MIN_LOW = 8'd20;
  localparam int SHARE_LIMIT = 95;

  typedef struct packed {
    logic capture;    // latch frame inputs
    logic fillHist;   // history <- all 255
    logic divStart;   // launch divider
    logic divRamp;    // divider operands: ramp (1) or bin (0)
    logic accumBin;   // add quotient into cumulative share
    logic pickIdx;    // scan shares, push raw index
    logic filterIdx;  // weighted smoothing into working index
    logic rampApply;  // add ramp quotient to working index
    logic finalize;   // clamp and register outputs
    logic bypassOut;  // full-brightness outputs
  } dimStrobe_t;
endpackage

// File: rtl/bldim_divider.sv
module bldim_divider #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0] remR, quoR, dvdR, dvsR;
  logic [CW-1:0] cntR;
  logic busy;
  logic [W:0] remShift;

  assign remShift = {remR, quoR[W-1]};
  assign quotient = quoR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0; quoR <= '0; dvdR <= '0; dvsR <= '1;
      cntR <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remR <= '0;
        quoR <= dividend;
        dvdR <= dividend;
        dvsR <= divisor;
        cntR <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        if (remShift >= {1'b0, dvsR}) begin
          remR <= W'(remShift - {1'b0, dvsR});
          quoR <= {quoR[W-2:0], 1'b1};
        end else begin
          remR <= remShift[W-1:0];
          quoR <= {quoR[W-2:0], 1'b0};
        end
        cntR <= cntR - CW'(1);
        if (cntR == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: each finished division is exact: q*d + r == n, r < d
  assert_div_exact_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (({{W{1'b0}}, quoR} * {{W{1'b0}}, dvsR}) + {{W{1'b0}}, remR} == {{W{1'b0}}, dvdR})
             && (remR < dvsR));
endmodule

// File: rtl/bldim_datapath.sv
module bldim_datapath
  import bldim_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int HIST_LEN = 8,
  parameter int WGT_W = 11,
  parameter logic [NUM_BINS*8-1:0] IDX_TABLE = '0,
  parameter logic [HIST_LEN*WGT_W-1:0] WEIGHTS = '0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  dimStrobe_t                cs,
  input  logic [NUM_BINS*CNT_W-1:0] binCounts,
  input  logic [CNT_W-1:0]          normSize,
  input  logic [7:0]                backlight,
  input  logic [7:0]                lowLimit,
  output logic                      belowLow,
  output logic                      needRamp,
  output logic                      divDone,
  output logic                      lastBin,
  output logic [7:0]                adjIndex,
  output logic [8:0]                dimming,
  output logic [6:0]                lutPage
);
  localparam int CUM_W = CNT_W + BIN_W;
  localparam int ACC_W = 8 + WGT_W + $clog2(HIST_LEN) + 1;
  localparam logic [7:0] FLOOR_IDX = IDX_TABLE[7:0];

  function automatic logic [7:0] tableAt(input int k);
    return IDX_TABLE[k*8 +: 8];
  endfunction

  logic [CNT_W-1:0] cntR [NUM_BINS];
  logic [CUM_W-1:0] cumR [NUM_BINS];
  logic [CUM_W-1:0] runSum;
  logic [CNT_W-1:0] sizeR;
  logic [7:0] blR, lowR, idxR;
  logic [BIN_W-1:0] binIdx;
  logic [7:0] histR [HIST_LEN];

  // effective low limit from the raw input
  logic [7:0] effLow;
  assign effLow = (lowLimit < MIN_LOW) ? FALLBACK_LOW : lowLimit;
  assign belowLow = backlight < effLow;
  assign lastBin = binIdx == BIN_W'(NUM_BINS - 1);

  // ramp thresholds
  logic [7:0] spanV, highV, distV;
  logic [15:0] rampProd;
  assign spanV = 8'((8'd255 - lowR) / 8'd5);
  assign highV = lowR + spanV;
  assign needRamp = blR < highV;
  assign distV = highV - blR;
  assign rampProd = 16'(8'd255 - idxR) * 16'(distV);

  // shared divider
  logic [CNT_W-1:0] divNum, divDen, divQuot;
  assign divNum = cs.divRamp ? CNT_W'(rampProd) : cntR[binIdx];
  assign divDen = cs.divRamp ? ((spanV == 8'd0) ? CNT_W'(1) : CNT_W'(spanV)) : sizeR;

  bldim_divider #(.W(CNT_W)) uDiv (
    .clk(clk), .rstN(rstN), .start(cs.divStart),
    .dividend(divNum), .divisor(divDen),
    .quotient(divQuot), .done(divDone)
  );

  // downward scan == highest bin below the share limit
  logic foundAny;
  logic [BIN_W-1:0] foundIdx;
  logic [7:0] rawIdx;
  always_comb begin
    foundAny = 1'b0;
    foundIdx = '0;
    for (int i = 0; i < NUM_BINS; i++) begin
      if (cumR[i] < CUM_W'(SHARE_LIMIT)) begin
        foundAny = 1'b1;
        foundIdx = BIN_W'(i);
      end
    end
    if (foundAny && foundIdx == BIN_W'(NUM_BINS - 1)) rawIdx = tableAt(NUM_BINS - 1);
    else if (!foundAny || foundIdx == '0)              rawIdx = tableAt(0);
    else                                               rawIdx = tableAt(int'(foundIdx) + 1);
  end

  // weighted smoothing over the history
  logic [ACC_W-1:0] acc, accShift;
  logic [7:0] firIdx;
  always_comb begin
    acc = '0;
    for (int s = 0; s < HIST_LEN; s++)
      acc = acc + ACC_W'(histR[s]) * ACC_W'(WEIGHTS[s*WGT_W +: WGT_W]);
    accShift = acc >> 10;
    firIdx = (accShift > ACC_W'(255)) ? 8'd255 : accShift[7:0];
  end

  logic [8:0] rampSum;
  logic [7:0] clampIdx;
  assign rampSum = {1'b0, idxR} + 9'(divQuot);
  assign clampIdx = (idxR < FLOOR_IDX) ? FLOOR_IDX : idxR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BINS; i++) begin
        cntR[i] <= '0;
        cumR[i] <= '0;
      end
      runSum <= '0; sizeR <= CNT_W'(1); blR <= '0; lowR <= FALLBACK_LOW;
      idxR <= 8'd255; binIdx <= '0;
    end else begin
      if (cs.capture) begin
        for (int i = 0; i < NUM_BINS; i++) cntR[i] <= binCounts[i*CNT_W +: CNT_W];
        sizeR <= (normSize == '0) ? CNT_W'(1) : normSize;
        blR <= backlight;
        lowR <= effLow;
        runSum <= '0;
        binIdx <= '0;
      end
      if (cs.accumBin) begin
        cumR[binIdx] <= runSum + CUM_W'(divQuot);
        runSum <= runSum + CUM_W'(divQuot);
        binIdx <= binIdx + BIN_W'(1);
      end
      if (cs.filterIdx) idxR <= firIdx;
      if (cs.rampApply) idxR <= rampSum[8] ? 8'd255 : rampSum[7:0];
    end
  end

  // history: oldest in slot 0, newest in the last slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < HIST_LEN; s++) histR[s] <= 8'd255;
    end else if (!enable || cs.fillHist) begin
      for (int s = 0; s < HIST_LEN; s++) histR[s] <= 8'd255;
    end else if (cs.pickIdx) begin
      for (int s = 0; s < HIST_LEN - 1; s++) histR[s] <= histR[s+1];
      histR[HIST_LEN-1] <= rawIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adjIndex <= 8'd255; dimming <= 9'd256; lutPage <= 7'd127;
    end else if (cs.bypassOut) begin
      adjIndex <= 8'd255; dimming <= 9'd256; lutPage <= 7'd127;
    end else if (cs.finalize) begin
      adjIndex <= clampIdx;
      dimming <= {1'b0, clampIdx} + 9'd1;
      lutPage <= 7'(clampIdx - 8'd128);
    end
  end

  // R9: dimming always one above the index
  assert_dim_tracks_index_R9: assert property (@(posedge clk) disable iff (!rstN)
    dimming == {1'b0, adjIndex} + 9'd1);
  // R9: index never below the table floor
  assert_index_floor_R9: assert property (@(posedge clk) disable iff (!rstN)
    adjIndex >= FLOOR_IDX);
endmodule

// File: rtl/bldim_control.sv
module bldim_control
  import bldim_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       start,
  input  logic       belowLow,
  input  logic       divDone,
  input  logic       lastBin,
  input  logic       needRamp,
  output dimStrobe_t cs,
  output logic       done
);
  typedef enum logic [2:0] {
    S_IDLE, S_BIN_GO, S_BIN_WAIT, S_PICK, S_FILTER, S_RAMP_CHK, S_RAMP_WAIT, S_FINISH
  } ctlState_t;

  ctlState_t state, nextState;
  logic frameOdd, runFlag;
  logic acceptStart;

  assign acceptStart = (state == S_IDLE) && start && enable;

  always_comb begin
    cs = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (acceptStart && !frameOdd) begin
          if (!runFlag) cs.bypassOut = 1'b1;
          else if (belowLow) begin
            cs.bypassOut = 1'b1;
            cs.fillHist = 1'b1;
          end else begin
            cs.capture = 1'b1;
            nextState = S_BIN_GO;
          end
        end
      end
      S_BIN_GO: begin
        cs.divStart = 1'b1;
        nextState = S_BIN_WAIT;
      end
      S_BIN_WAIT: begin
        if (divDone) begin
          cs.accumBin = 1'b1;
          nextState = lastBin ? S_PICK : S_BIN_GO;
        end
      end
      S_PICK: begin
        cs.pickIdx = 1'b1;
        nextState = S_FILTER;
      end
      S_FILTER: begin
        cs.filterIdx = 1'b1;
        nextState = S_RAMP_CHK;
      end
      S_RAMP_CHK: begin
        if (needRamp) begin
          cs.divStart = 1'b1;
          cs.divRamp = 1'b1;
          nextState = S_RAMP_WAIT;
        end else nextState = S_FINISH;
      end
      S_RAMP_WAIT: begin
        if (divDone) begin
          cs.rampApply = 1'b1;
          nextState = S_FINISH;
        end
      end
      S_FINISH: begin
        cs.finalize = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
    if (!enable) begin
      cs = '0;
      nextState = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; frameOdd <= 1'b0; runFlag <= 1'b0; done <= 1'b0;
    end else begin
      state <= nextState;
      done <= cs.finalize | cs.bypassOut;
      if (!enable) begin
        frameOdd <= 1'b0;
        runFlag <= 1'b0;
      end else if (acceptStart) begin
        frameOdd <= ~frameOdd;
        if (!frameOdd) runFlag <= 1'b1;
      end
    end
  end

  // R1: a start while disabled yields no done
  assert_off_start_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && !enable) |=> !done);
  // R2: an odd start is skipped and the controller stays idle
  assert_odd_skip_R2: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStart && frameOdd) |=> (!done && state == S_IDLE));
  // R3: the first processed frame answers at once
  assert_first_run_bypass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStart && !frameOdd && !runFlag) |=> done);
  // R10: done lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/bldim_top.sv
module bldim_top
  import bldim_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int HIST_LEN = 8,
  parameter int WGT_W = 11,
  parameter logic [NUM_BINS*8-1:0] IDX_TABLE =
    {8'd240, 8'd224, 8'd208, 8'd192, 8'd176, 8'd160, 8'd144, 8'd128},
  parameter logic [HIST_LEN*WGT_W-1:0] WEIGHTS =
    {11'd192, 11'd192, 11'd160, 11'd128, 11'd128, 11'd96, 11'd64, 11'd64}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic                      start,
  input  logic [NUM_BINS*CNT_W-1:0] binCounts,
  input  logic [CNT_W-1:0]          normSize,
  input  logic [7:0]                backlight,
  input  logic [7:0]                lowLimit,
  output logic [7:0]                adjIndex,
  output logic [8:0]                dimming,
  output logic [6:0]                lutPage,
  output logic                      done
);
  dimStrobe_t cs;
  logic belowLow, needRamp, divDone, lastBin;

  bldim_control uCtl (
    .clk(clk), .rstN(rstN), .enable(enable), .start(start),
    .belowLow(belowLow), .divDone(divDone), .lastBin(lastBin),
    .needRamp(needRamp), .cs(cs), .done(done)
  );

  bldim_datapath #(
    .CNT_W(CNT_W), .HIST_LEN(HIST_LEN), .WGT_W(WGT_W),
    .IDX_TABLE(IDX_TABLE), .WEIGHTS(WEIGHTS)
  ) uDp (
    .clk(clk), .rstN(rstN), .enable(enable), .cs(cs),
    .binCounts(binCounts), .normSize(normSize),
    .backlight(backlight), .lowLimit(lowLimit),
    .belowLow(belowLow), .needRamp(needRamp), .divDone(divDone),
    .lastBin(lastBin), .adjIndex(adjIndex), .dimming(dimming),
    .lutPage(lutPage)
  );
endmodule

// File: tb/tb_bldim_top.sv
module tb_bldim_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYCLES = 330;
  localparam int TBL [8] = '{128, 144, 160, 176, 192, 208, 224, 240};
  localparam int WGT [8] = '{64, 64, 96, 128, 128, 160, 192, 192};

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, start = 1'b0;
  logic [191:0] binCounts = '0;
  logic [23:0] normSize = '0;
  logic [7:0] backlight = '0, lowLimit = '0;
  logic [7:0] adjIndex;
  logic [8:0] dimming;
  logic [6:0] lutPage;
  logic done;

  int checks = 0, errors = 0;
  int mHist [8];
  bit mOdd = 1'b0, mRun = 1'b0;
  int stimCnt [8];
  int lastIdx = 255;
  bit finished = 1'b0;

  bldim_top dut (
    .clk(clk), .rstN(rstN), .enable(enable), .start(start),
    .binCounts(binCounts), .normSize(normSize), .backlight(backlight),
    .lowLimit(lowLimit), .adjIndex(adjIndex), .dimming(dimming),
    .lutPage(lutPage), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    mOdd = 1'b0; mRun = 1'b0;
    for (int i = 0; i < 8; i++) mHist[i] = 255;
  endtask

  task automatic modelFrame(input int bl, input int low, input int sz,
                            output bit expDone, output int expIdx, output string tag);
    int el, size, cum, found, raw, acc, idx, hi;
    expDone = 1'b0; expIdx = lastIdx;
    if (!enable) begin tag = "R1"; return; end
    if (mOdd) begin mOdd = 1'b0; tag = "R2"; return; end
    mOdd = 1'b1;
    expDone = 1'b1;
    if (!mRun) begin mRun = 1'b1; expIdx = 255; tag = "R3"; return; end
    el = (low < 20) ? 85 : low;
    if (bl < el) begin
      for (int i = 0; i < 8; i++) mHist[i] = 255;
      expIdx = 255; tag = (low < 20) ? "R4" : "R5"; return;
    end
    size = (sz == 0) ? 1 : sz;
    cum = 0; found = -1;
    for (int i = 0; i < 8; i++) begin
      cum = cum + stimCnt[i] / size;
      if (cum < 95) found = i;
    end
    if (found == 7) raw = TBL[7];
    else if (found <= 0) raw = TBL[0];
    else raw = TBL[found + 1];
    for (int i = 0; i < 7; i++) mHist[i] = mHist[i+1];
    mHist[7] = raw;
    acc = 0;
    for (int i = 0; i < 8; i++) acc += WGT[i] * mHist[i];
    idx = acc >> 10;
    hi = el + (255 - el) / 5;
    if (bl < hi) idx = idx + (255 - idx) * (hi - bl) / (hi - el);
    if (idx > 255) idx = 255;
    if (idx < TBL[0]) idx = TBL[0];
    expIdx = idx;
    if (sz == 0) tag = "R6";
    else if (low < 20) tag = "R4";
    else tag = (bl < hi) ? "R8" : "R7";
  endtask

  task automatic setEnable(input bit en);
    @(negedge clk);
    enable = en;
    if (!en) modelClear();
    repeat (2) @(negedge clk);
  endtask

  task automatic doFrame(input int bl, input int low, input int sz);
    bit expDone, got;
    int expIdx, gi, gd, gp;
    string tag;
    modelFrame(bl, low, sz, expDone, expIdx, tag);
    @(negedge clk);
    backlight = 8'(bl); lowLimit = 8'(low); normSize = 24'(sz);
    for (int i = 0; i < 8; i++) binCounts[i*24 +: 24] = 24'(stimCnt[i]);
    start = 1'b1;
    got = 1'b0; gi = 0; gd = 0; gp = 0;
    for (int c = 0; c < WAIT_CYCLES; c++) begin
      @(negedge clk);
      if (c == 0) start = 1'b0;
      if (done) begin
        got = 1'b1; gi = int'(adjIndex); gd = int'(dimming); gp = int'(lutPage);
        @(negedge clk);
        checkEq("R10", "done width", int'(done), 0);
        break;
      end
    end
    checkEq(tag, "done seen", int'(got), int'(expDone));
    if (expDone) begin
      checkEq(tag, "index", gi, expIdx);
      checkEq("R9", "dimming", gd, expIdx + 1);
      checkEq("R9", "page", gp, (expIdx - 128) & 127);
      lastIdx = expIdx;
    end else begin
      checkEq(tag, "index held", int'(adjIndex), lastIdx);
      checkEq(tag, "dimming held", int'(dimming), lastIdx + 1);
    end
  endtask

  task automatic setCnt(input int c0, input int c1, input int c2, input int c3,
                        input int c4, input int c5, input int c6, input int c7);
    stimCnt[0] = c0; stimCnt[1] = c1; stimCnt[2] = c2; stimCnt[3] = c3;
    stimCnt[4] = c4; stimCnt[5] = c5; stimCnt[6] = c6; stimCnt[7] = c7;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sz;
    void'($urandom(32'd20240611));
    modelClear();
    setCnt(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    // R10: reset state
    checkEq("R10", "reset index", int'(adjIndex), 255);
    checkEq("R10", "reset dimming", int'(dimming), 256);
    checkEq("R10", "reset page", int'(lutPage), 127);
    checkEq("R10", "reset done", int'(done), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    doFrame(200, 100, 10);                          // R1 disabled
    setEnable(1'b1);
    doFrame(200, 100, 10);                          // R3 first run
    doFrame(200, 100, 10);                          // R2 skipped
    setCnt(500, 500, 500, 500, 500, 500, 500, 500);
    doFrame(255, 100, 1);                           // R6 none below -> table[0]
    doFrame(255, 100, 1);                           // R2
    setCnt(0, 0, 0, 0, 0, 0, 0, 0);
    doFrame(255, 100, 0);                           // R6 zero size, bin 7
    doFrame(255, 100, 0);
    setCnt(10, 200, 0, 0, 0, 0, 0, 0);
    doFrame(255, 100, 1);                           // R6 bin 0 only
    doFrame(255, 100, 1);
    setCnt(20, 20, 20, 20, 100, 0, 0, 0);
    doFrame(255, 100, 1);                           // R6 middle bin
    doFrame(255, 100, 1);
    doFrame(100, 100, 1);                           // R8 full ramp to 255
    doFrame(100, 100, 1);
    doFrame(50, 10, 1);                             // R4 fallback limit bypass
    doFrame(50, 10, 1);
    doFrame(90, 10, 1);                             // R4 algorithm with limit 85
    doFrame(90, 10, 1);
    doFrame(60, 120, 1);                            // R5 refill
    doFrame(60, 120, 1);
    doFrame(255, 120, 1);                           // R7 after refill
    setEnable(1'b0);
    doFrame(255, 120, 1);                           // R1
    setEnable(1'b1);

    for (int k = 0; k < 150; k++) begin
      if ($urandom_range(0, 24) == 0) setEnable(!enable);
      sz = int'($urandom_range(0, 1500));
      for (int i = 0; i < 8; i++) stimCnt[i] = int'($urandom_range(0, sz * 30 + 60));
      doFrame(int'($urandom_range(0, 255)),
              ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 19))
                                          : int'($urandom_range(20, 255)), sz);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule